// File: doc/BRIEF.md
# Serial Control Register Bank with Status Readback

This block is a two-wire serial slave that holds a bank of 23 byte-wide control registers for a video processing chip. It responds to the 7-bit device address 1000101 (write byte 8A hex, read byte 8B hex). A write transfer sends the device address, one subaddress byte and then any number of data bytes. The subaddress advances after every data byte, so a host can load the whole bank in one burst. Every register is presented in parallel on a flat output bus for the rest of the chip.

A read transfer takes no subaddress. It returns two status bytes in turn, always starting with the first. The first status byte carries a power-on flag that reset sets. The flag clears once that byte has been shifted out, so software can see that the chip lost its settings. The second status byte carries a vertical-deflection-failure input and echoes the two crystal-selection bits last written. Software can read them back to confirm that this critical setting arrived intact. A one-cycle completion strobe marks the moment every subaddress of the bank has been written at least once since reset.

Top module: `i2c_ctrl_regs`

## Requirements
- R1: Only the device address 1000101 is acknowledged (ACK = SDA pulled low in the ninth clock). Any other address is left unacknowledged, and the rest of that transfer has no effect.
- R2: In a write, the byte after the address sets the pointer. Each following data byte is stored in register `ptr` and appears on `regs_o[8*ptr +: 8]`. The pointer then advances by one, and every byte is acknowledged.
- R3: After a data byte written at pointer 16 hex (22), the pointer returns to 00.
- R4: A data byte sent while the pointer is 17 hex or above (including FE) is acknowledged and leaves the bank unchanged. The pointer still advances and rolls over from FF to 00.
- R5: Registers 13, 14 and 15 hex accept writes but always read as zero on `regs_o`.
- R6: A read returns status byte 0 = {power-on flag, `stat0_i[6:0]`}, then status byte 1 = {`vfail_i`, `stat1_i[4:0]`, register 00 bits 1:0}. The two bytes alternate for as long as the master acknowledges.
- R7: The power-on flag is 1 after reset. It clears after status byte 0 has been transmitted and stays 0 until the next reset.
- R8: `cfg_done_o` pulses high for exactly one clock when the last of the subaddresses 00..16 hex not yet written since reset is written. It does not pulse again until the next reset.
- R9: Every read transfer begins with status byte 0, and a master NACK ends the slave's driving of SDA.
- R10: The slave changes its SDA pull-down only while SCL is low, and `sda_oe` is 0 while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst_n | input | 1 | Active-low asynchronous-free reset (sampled on clk) |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the open-drain data line low |
| stat0_i | input | 7 | Status bits shown in status byte 0 bits 6:0 |
| vfail_i | input | 1 | Vertical deflection failure, status byte 1 bit 7 |
| stat1_i | input | 5 | Status bits shown in status byte 1 bits 6:2 |
| regs_o | output | 184 | Register bank, register n at bits 8n+7..8n |
| cfg_done_o | output | 1 | One-cycle pulse when the bank is fully written |

## Verification
The hardest condition to reach is the completion strobe. It needs every one of the 23 subaddresses to be written, and the bench must also show that writes to spare and out-of-range addresses neither block nor fake that completion. The stimulus fills subaddresses 00 to 15 hex with two bursts. It then pokes 17 and FE hex, letting the second poke roll over into 00. Finally it starts a burst at 16 hex so that the wrap to 00 and the final missing register arrive in the same transfer. A later full rewrite confirms that the strobe stays silent.

// File: rtl/i2c_ctrl_regs.sv
module i2c_ctrl_regs #(
  parameter logic [6:0] DEV_ADDR = 7'h45,
  parameter int NREG = 23,
  parameter int SPARE_LO = 19,
  parameter int SPARE_HI = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [6:0]        stat0_i,
  input  logic              vfail_i,
  input  logic [4:0]        stat1_i,
  output logic [NREG*8-1:0] regs_o,
  output logic              cfg_done_o
);
  localparam int LAST = NREG - 1;
  localparam int IW = $clog2(NREG);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_SUB, S_WDAT, S_RDAT} st_t;

  st_t            st;
  logic [2:0]     scl_q, sda_q;
  logic [3:0]     bitcnt;
  logic [7:0]     shreg, tx, ptr;
  logic           rw, mack, sel, por;
  logic [7:0]     bank [NREG];
  logic [NREG-1:0] written;

  wire scl_rise = scl_q[1] & ~scl_q[2];
  wire scl_fall = ~scl_q[1] & scl_q[2];
  wire start = scl_q[1] & scl_q[2] & ~sda_q[1] & sda_q[2];
  wire stop  = scl_q[1] & scl_q[2] & sda_q[1] & ~sda_q[2];

  wire [7:0] stat0 = {por, stat0_i};
  wire [7:0] stat1 = {vfail_i, stat1_i, bank[0][1:0]};
  wire in_rng = ptr < 8'(NREG);
  wire spare  = (ptr >= 8'(SPARE_LO)) && (ptr <= 8'(SPARE_HI));
  wire wr_evt = scl_fall && (bitcnt == 4'd8) && (st == S_WDAT);
  wire [NREG-1:0] wr_bit = (wr_evt && in_rng) ? (NREG'(1) << ptr) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 3'b111; sda_q <= 3'b111;
      st <= S_IDLE; bitcnt <= '0; shreg <= '0; tx <= '0; ptr <= '0;
      rw <= 1'b0; mack <= 1'b0; sel <= 1'b0; por <= 1'b1;
      sda_oe <= 1'b0; written <= '0; cfg_done_o <= 1'b0;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
      written <= written | wr_bit;
      cfg_done_o <= ~&written & &(written | wr_bit);
      if (start) begin
        st <= S_ADDR; bitcnt <= '0; sel <= 1'b0; sda_oe <= 1'b0;
      end else if (stop) begin
        st <= S_IDLE; sda_oe <= 1'b0;
      end else if (st != S_IDLE) begin
        if (scl_rise && bitcnt != 4'd9) begin
          bitcnt <= bitcnt + 4'd1;
          if (bitcnt < 4'd8 && st != S_RDAT) shreg <= {shreg[6:0], sda_q[1]};
          if (bitcnt == 4'd8 && st == S_RDAT) mack <= ~sda_q[1];
        end
        if (scl_fall) begin
          if (bitcnt == 4'd8) begin
            case (st)
              S_ADDR: if (shreg[7:1] == DEV_ADDR) begin
                        sda_oe <= 1'b1; rw <= shreg[0];
                      end else st <= S_IDLE;
              S_SUB:  begin ptr <= shreg; sda_oe <= 1'b1; end
              S_WDAT: begin
                        ptr <= (ptr == 8'(LAST)) ? 8'd0 : ptr + 8'd1;
                        sda_oe <= 1'b1;
                      end
              S_RDAT: begin
                        sda_oe <= 1'b0;
                        if (!sel) por <= 1'b0;
                        sel <= ~sel;
                      end
              default: ;
            endcase
          end else if (bitcnt == 4'd9) begin
            bitcnt <= '0;
            sda_oe <= 1'b0;
            case (st)
              S_ADDR: if (rw) begin
                        st <= S_RDAT; tx <= stat0; sda_oe <= ~stat0[7];
                      end else st <= S_SUB;
              S_SUB:  st <= S_WDAT;
              S_RDAT: if (mack) begin
                        tx <= sel ? stat1 : stat0;
                        sda_oe <= ~(sel ? stat1[7] : stat0[7]);
                      end else st <= S_IDLE;
              default: ;
            endcase
          end else if (st == S_RDAT && bitcnt != 4'd0) begin
            sda_oe <= ~tx[6];
            tx <= {tx[6:0], 1'b0};
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) bank[i] <= '0;
    end else if (wr_evt && in_rng && !spare) begin
      bank[ptr[IW-1:0]] <= shreg;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regs_o[8*g +: 8] = bank[g];
  end

  for (genvar s = SPARE_LO; s <= SPARE_HI; s++) begin : g_spare
    assert_spare_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      regs_o[8*s +: 8] == 8'h00);
  end

  assert_drive_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_q[2]);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done_o |=> !cfg_done_o);

  assert_done_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done_o |-> &written);

  assert_por_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !por |=> !por);

  assert_ptr_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && ptr == 8'(LAST)) |=> ptr == 8'd0);
endmodule

// File: tb/i2c_ctrl_regs_test.sv
`timescale 1ns/1ps
module i2c_ctrl_regs_test;
  localparam int NB = 23;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic m_scl = 1'b1, m_low = 1'b0;
  logic [6:0] st0 = 7'h2B;
  logic vf = 1'b0;
  logic [4:0] st1 = 5'h11;
  wire sda_oe, done;
  wire [NB*8-1:0] regs;
  wire sda_bus = ~(m_low | sda_oe);

  i2c_ctrl_regs uut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .stat0_i(st0), .vfail_i(vf), .stat1_i(st1), .regs_o(regs), .cfg_done_o(done));

  int nchk = 0, nfail = 0, done_cnt = 0, exp_done = 0;
  byte unsigned exp_bank[NB];
  bit wrt[NB];
  bit exp_por = 1'b1;
  bit cmp_en = 1'b0;
  logic [NB*8-1:0] ev;

  always_comb for (int k = 0; k < NB; k++) ev[k*8 +: 8] = exp_bank[k];

  task automatic chk(bit ok, string req, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) done_cnt++;
    if (rst_n && cmp_en) begin
      nchk++;
      if (regs !== ev) begin
        nfail++;
        $display("FAIL R2/R5 bank actual=%h expected=%h", regs, ev);
      end
    end
  end

  task automatic q(); repeat (8) @(negedge clk); endtask

  task automatic i_start();
    m_low = 1'b0; q(); m_scl = 1'b1; q(); m_low = 1'b1; q(); m_scl = 1'b0; q();
  endtask

  task automatic i_stop();
    m_low = 1'b1; q(); m_scl = 1'b1; q(); m_low = 1'b0; q();
  endtask

  task automatic send(input byte unsigned b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; q(); m_scl = 1'b1; q(); q(); m_scl = 1'b0; q();
    end
    m_low = 1'b0; q(); m_scl = 1'b1; q(); ack = ~sda_bus; q(); m_scl = 1'b0; q();
  endtask

  task automatic recv(input bit mack, output byte unsigned b);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      q(); m_scl = 1'b1; q(); b[i] = sda_bus; q(); m_scl = 1'b0;
    end
    m_low = mack; q(); m_scl = 1'b1; q(); q(); m_scl = 1'b0; q(); m_low = 1'b0;
  endtask

  task automatic model_wr(inout byte unsigned p, input byte unsigned b);
    if (p < NB) begin
      wrt[p] = 1'b1;
      if (!(p >= 19 && p <= 21)) exp_bank[p] = b;
    end
    if (exp_done == 0) begin
      bit all = 1'b1;
      for (int k = 0; k < NB; k++) all &= wrt[k];
      if (all) exp_done = 1;
    end
    p = (p == 8'd22) ? 8'd0 : p + 8'd1;
  endtask

  task automatic wr(input logic [6:0] a, input byte unsigned sub, input byte unsigned d[$]);
    bit ack;
    byte unsigned p = sub;
    i_start();
    send({a, 1'b0}, ack);
    chk(ack == (a == 7'h45), "R1 address ack", ack, a == 7'h45);
    if (ack) begin
      send(sub, ack);
      chk(ack, "R2 subaddress ack", ack, 1);
      foreach (d[i]) begin
        cmp_en = 1'b0;
        send(d[i], ack);
        chk(ack, (p >= NB) ? "R4 data ack" : "R2 data ack", ack, 1);
        model_wr(p, d[i]);
        cmp_en = 1'b1;
      end
    end
    i_stop();
  endtask

  task automatic rd(input int n);
    bit ack;
    bit sel = 1'b0;
    byte unsigned b, e;
    i_start();
    send({7'h45, 1'b1}, ack);
    chk(ack, "R1 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv(i != n - 1, b);
      e = sel ? {vf, st1, exp_bank[0][1:0]} : {exp_por, st0};
      chk(b == e, (i == 0) ? "R9 first byte" : (sel ? "R6 status1" : "R7 status0"), b, e);
      if (!sel) exp_por = 1'b0;
      sel = ~sel;
    end
    chk(!sda_oe, "R9 released after NACK", sda_oe, 0);
    i_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    byte unsigned d[$];
    foreach (exp_bank[k]) begin exp_bank[k] = 8'h00; wrt[k] = 1'b0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    q();
    chk(regs == '0, "R2 reset bank", regs[63:0], 0);
    chk(!done, "R8 reset strobe", done, 0);
    chk(!sda_oe, "R10 idle release", sda_oe, 0);
    cmp_en = 1'b1;

    wr(7'h46, 8'h00, '{8'h11});
    rd(3);

    d = {};
    for (int i = 0; i < 11; i++) d.push_back(8'h80 + 8'(i));
    d[0] = 8'h03;
    wr(7'h45, 8'h00, d);
    chk(regs[1:0] == 2'b11, "R2 reg00", regs[7:0], 8'h03);

    d = {};
    for (int i = 0; i < 11; i++) d.push_back(8'hC0 + 8'(i));
    wr(7'h45, 8'h0B, d);
    chk(regs[19*8 +: 24] == 24'h0, "R5 spare zero", regs[19*8 +: 24], 0);
    q();
    chk(done_cnt == 0, "R8 no early strobe", done_cnt, 0);

    wr(7'h45, 8'h17, '{8'h55});
    wr(7'h45, 8'hFE, '{8'h66, 8'h77, 8'h01});
    chk(regs[7:0] == 8'h01, "R4 rollover to 00", regs[7:0], 8'h01);
    q();
    chk(done_cnt == 0, "R8 invalid writes do not complete", done_cnt, 0);

    wr(7'h45, 8'h16, '{8'hA5, 8'h02});
    q();
    chk(regs[22*8 +: 8] == 8'hA5, "R3 last register", regs[22*8 +: 8], 8'hA5);
    chk(regs[7:0] == 8'h02, "R3 wrap to 00", regs[7:0], 8'h02);
    chk(done_cnt == 1, "R8 strobe once", done_cnt, 1);

    d = {};
    for (int i = 0; i < NB; i++) d.push_back(8'h30 + 8'(i));
    wr(7'h45, 8'h00, d);
    q();
    chk(done_cnt == 1, "R8 no second strobe", done_cnt, 1);
    chk(done_cnt == exp_done, "R8 model agreement", done_cnt, exp_done);

    vf = 1'b1; st1 = 5'h0A; st0 = 7'h55;
    rd(2);
    rd(1);
    chk(!sda_oe, "R10 idle after reads", sda_oe, 0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule